// File: doc/BRIEF.md
# Buffered Capture Channel

This block is a single input-capture channel for a 16-bit timer. When a capture pulse arrives, the channel takes a timestamp of the running counter value. It holds up to two timestamps: a capture register, which software reads, and a one-deep buffer in front of that register. A capture flag shows that the capture register holds an unread value. A buffer-valid flag shows that a second value is waiting behind it.

Software removes values with a read strobe. The strobe returns the capture register. If a buffered value exists, the strobe moves it forward into the capture register; if not, the strobe retires the capture flag.

A capture that arrives while both slots are occupied cannot be stored. The channel drops it, leaves both stored values as they were, and sets a sticky error flag. Two clear strobes remove the flags. A registered interrupt request combines each flag with its enable.

Top module: `capbuf_channel`

## Requirements
- R1: A synchronous active-high reset clears the capture flag, buffer-valid, the error flag, the interrupt request, the capture register and the buffer.
- R2: A capture while the capture flag is clear loads the counter value into the capture register and sets the capture flag at the next clock edge.
- R3: A capture while the capture flag is set and buffer-valid is clear loads the counter value into the buffer and sets buffer-valid. The capture register stays unchanged.
- R4: A capture while both flags are set is rejected. The capture register and the buffer keep their values, and the error flag is set.
- R5: A read while buffer-valid is set returns the capture register, moves the buffer into the capture register, and clears buffer-valid. The capture flag stays set.
- R6: A read while the capture flag is set and buffer-valid is clear clears the capture flag.
- R7: When a read and a capture occur in the same cycle, the read is applied first. With both slots full, the capture therefore lands in the buffer and no error is raised.
- R8: The error flag stays set until clr_err_i is asserted. If an overflow and clr_err_i occur in the same cycle, the flag ends up set.
- R9: clr_cap_i clears both the capture flag and buffer-valid. A capture in the same cycle is applied after the clear and loads the capture register.
- R10: After every clock edge, irq_o equals (capture flag AND cap_ie_i) OR (error flag AND err_ie_i), using the enables sampled at that edge.
- R11: A read while the channel is empty has no effect on any flag or on the capture register.
- R12: Buffer-valid is never set while the capture flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | W | Running timer value to be captured |
| capture_i | input | 1 | One-cycle capture event |
| rd_i | input | 1 | Read strobe that pops the capture register |
| clr_cap_i | input | 1 | Clears capture flag and buffer-valid |
| clr_err_i | input | 1 | Clears the error flag |
| cap_ie_i | input | 1 | Capture interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| rd_data_o | output | W | Capture register contents |
| cap_flag_o | output | 1 | Capture flag |
| buf_valid_o | output | 1 | Buffer-valid flag |
| err_flag_o | output | 1 | Sticky overflow error flag |
| irq_o | output | 1 | Registered, enable-gated interrupt request |

## Verification
The bench fills the channel to two entries and then sends a third capture. A design that overwrote a slot would fail here: the scoreboard would see a changed capture register or a changed buffer value on the next pop. The bench also applies a read and a capture in the same cycle while the channel is full. A design that handled the capture first would raise a false error and lose the new timestamp. The bench further pairs clears with captures and overflows with error clears, to show whether the set or the clear wins. Finally, it sends reads into an empty channel. A careless decode would pop a stale buffer value or corrupt a flag.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_LOAD_REG = 2'd1,
    OP_LOAD_BUF = 2'd2,
    OP_REJECT   = 2'd3
  } cap_op_e;
endpackage

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
  import capbuf_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    capture_i,
  input  logic    rd_i,
  input  logic    clr_cap_i,
  input  logic    clr_err_i,
  output cap_op_e op_o,
  output logic    pop_o,
  output logic    cf_o,
  output logic    bv_o,
  output logic    err_o,
  output logic    cf_nxt_o,
  output logic    err_nxt_o
);
  logic cf_q, bv_q, err_q;
  logic cf_a, bv_a;
  logic cf_n, bv_n, err_n;
  cap_op_e op;

  always_comb begin
    // read first, then software clear, then the incoming capture
    cf_a = cf_q;
    bv_a = bv_q;
    if (rd_i && cf_q) begin
      if (bv_q) bv_a = 1'b0;
      else      cf_a = 1'b0;
    end
    if (clr_cap_i) begin
      cf_a = 1'b0;
      bv_a = 1'b0;
    end
    op    = OP_NONE;
    cf_n  = cf_a;
    bv_n  = bv_a;
    err_n = err_q & ~clr_err_i;
    if (capture_i) begin
      if (!cf_a) begin
        op   = OP_LOAD_REG;
        cf_n = 1'b1;
      end else if (!bv_a) begin
        op   = OP_LOAD_BUF;
        bv_n = 1'b1;
      end else begin
        op    = OP_REJECT;
        err_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cf_q  <= 1'b0;
      bv_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cf_q  <= cf_n;
      bv_q  <= bv_n;
      err_q <= err_n;
    end
  end

  assign op_o      = op;
  assign pop_o     = rd_i & cf_q & bv_q;
  assign cf_o      = cf_q;
  assign bv_o      = bv_q;
  assign err_o     = err_q;
  assign cf_nxt_o  = cf_n;
  assign err_nxt_o = err_n;
endmodule

// File: rtl/capbuf_store.sv
module capbuf_store
  import capbuf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  cap_op_e      op_i,
  input  logic         pop_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] reg_o
);
  logic [W-1:0] reg_q, buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
      buf_q <= '0;
    end else begin
      if (op_i == OP_LOAD_REG)  reg_q <= count_i;
      else if (pop_i)           reg_q <= buf_q;
      if (op_i == OP_LOAD_BUF)  buf_q <= count_i;
    end
  end

  assign reg_o = reg_q;
endmodule

// File: rtl/capbuf_irq.sv
module capbuf_irq (
  input  logic clk,
  input  logic rst,
  input  logic cf_nxt_i,
  input  logic err_nxt_i,
  input  logic cap_ie_i,
  input  logic err_ie_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (cf_nxt_i & cap_ie_i) | (err_nxt_i & err_ie_i);
  end
endmodule

// File: rtl/capbuf_channel.sv
module capbuf_channel
  import capbuf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] count_i,
  input  logic         capture_i,
  input  logic         rd_i,
  input  logic         clr_cap_i,
  input  logic         clr_err_i,
  input  logic         cap_ie_i,
  input  logic         err_ie_i,
  output logic [W-1:0] rd_data_o,
  output logic         cap_flag_o,
  output logic         buf_valid_o,
  output logic         err_flag_o,
  output logic         irq_o
);
  cap_op_e op;
  logic    pop, cf_nxt, err_nxt;

  capbuf_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .capture_i (capture_i),
    .rd_i      (rd_i),
    .clr_cap_i (clr_cap_i),
    .clr_err_i (clr_err_i),
    .op_o      (op),
    .pop_o     (pop),
    .cf_o      (cap_flag_o),
    .bv_o      (buf_valid_o),
    .err_o     (err_flag_o),
    .cf_nxt_o  (cf_nxt),
    .err_nxt_o (err_nxt)
  );

  capbuf_store #(.W(W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op),
    .pop_i   (pop),
    .count_i (count_i),
    .reg_o   (rd_data_o)
  );

  capbuf_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .cf_nxt_i  (cf_nxt),
    .err_nxt_i (err_nxt),
    .cap_ie_i  (cap_ie_i),
    .err_ie_i  (err_ie_i),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] count_i,
  input logic         capture_i,
  input logic         rd_i,
  input logic         clr_cap_i,
  input logic         clr_err_i,
  input logic         cap_ie_i,
  input logic         err_ie_i,
  input logic [W-1:0] rd_data_o,
  input logic         cap_flag_o,
  input logic         buf_valid_o,
  input logic         err_flag_o,
  input logic         irq_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!cap_flag_o && !buf_valid_o && !err_flag_o && !irq_o && rd_data_o == '0));

  a_r2_load_reg: assert property (@(posedge clk) disable iff (rst)
    (capture_i && !cap_flag_o && !rd_i && !clr_cap_i) |=> (cap_flag_o && rd_data_o == $past(count_i)));

  a_r3_load_buf: assert property (@(posedge clk) disable iff (rst)
    (capture_i && cap_flag_o && !buf_valid_o && !rd_i && !clr_cap_i)
      |=> (buf_valid_o && $stable(rd_data_o)));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (capture_i && cap_flag_o && buf_valid_o && !rd_i && !clr_cap_i)
      |=> (err_flag_o && buf_valid_o && $stable(rd_data_o)));

  a_r5_pop_buf: assert property (@(posedge clk) disable iff (rst)
    (rd_i && cap_flag_o && buf_valid_o && !capture_i && !clr_cap_i) |=> (cap_flag_o && !buf_valid_o));

  a_r6_pop_last: assert property (@(posedge clk) disable iff (rst)
    (rd_i && cap_flag_o && !buf_valid_o && !capture_i && !clr_cap_i) |=> !cap_flag_o);

  a_r7_read_first: assert property (@(posedge clk) disable iff (rst)
    (rd_i && capture_i && cap_flag_o && buf_valid_o && !clr_cap_i && !clr_err_i)
      |=> (buf_valid_o && err_flag_o == $past(err_flag_o)));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_flag_o && !clr_err_i) |=> err_flag_o);

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_cap_i && !capture_i) |=> (!cap_flag_o && !buf_valid_o));

  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == ((cap_flag_o && $past(cap_ie_i)) || (err_flag_o && $past(err_ie_i)))));

  a_r11_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !cap_flag_o && !capture_i) |=> (!cap_flag_o && $stable(rd_data_o)));

  a_r12_order: assert property (@(posedge clk) disable iff (rst)
    buf_valid_o |-> cap_flag_o);
endmodule

bind capbuf_channel capbuf_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .count_i     (count_i),
  .capture_i   (capture_i),
  .rd_i        (rd_i),
  .clr_cap_i   (clr_cap_i),
  .clr_err_i   (clr_err_i),
  .cap_ie_i    (cap_ie_i),
  .err_ie_i    (err_ie_i),
  .rd_data_o   (rd_data_o),
  .cap_flag_o  (cap_flag_o),
  .buf_valid_o (buf_valid_o),
  .err_flag_o  (err_flag_o),
  .irq_o       (irq_o)
);

// File: tb/test_capbuf_channel.sv
module test_capbuf_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] count_i = '0;
  logic         capture_i = 1'b0, rd_i = 1'b0, clr_cap_i = 1'b0, clr_err_i = 1'b0;
  logic         cap_ie_i = 1'b0, err_ie_i = 1'b0;
  logic [W-1:0] rd_data_o;
  logic         cap_flag_o, buf_valid_o, err_flag_o, irq_o;

  always #10 clk = ~clk;

  capbuf_channel #(.W(W)) i_capbuf_channel (.*);

  typedef struct {
    logic [W-1:0] data;
    logic         cf, bv, err, irq;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // reference model state
  logic [W-1:0] m_reg = '0, m_buf = '0;
  logic         m_cf = 0, m_bv = 0, m_err = 0;

  task automatic push_exp(input string tag);
    exp_t e;
    e.data = m_reg; e.cf = m_cf; e.bv = m_bv; e.err = m_err;
    e.irq  = (m_cf & cap_ie_i) | (m_err & err_ie_i);
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input bit cap, input logic [W-1:0] val, input bit rd,
                      input bit clrc, input bit clre, input string tag);
    capture_i = cap; count_i = val; rd_i = rd; clr_cap_i = clrc; clr_err_i = clre;
    if (rd && m_cf) begin
      if (m_bv) begin m_reg = m_buf; m_bv = 0; end
      else m_cf = 0;
    end
    if (clrc) begin m_cf = 0; m_bv = 0; end
    if (clre) m_err = 0;
    if (cap) begin
      if (!m_cf)      begin m_reg = val; m_cf = 1; end
      else if (!m_bv) begin m_buf = val; m_bv = 1; end
      else m_err = 1;
    end
    @(posedge clk);
    push_exp(tag);
    @(negedge clk);
    capture_i = 0; rd_i = 0; clr_cap_i = 0; clr_err_i = 0;
  endtask

  // monitor: compare outputs against the scoreboard away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (rd_data_o !== e.data || cap_flag_o !== e.cf || buf_valid_o !== e.bv ||
            err_flag_o !== e.err || irq_o !== e.irq) begin
          errors++;
          $display("FAIL %s: got data=%h cf=%b bv=%b err=%b irq=%b exp data=%h cf=%b bv=%b err=%b irq=%b",
                   e.tag, rd_data_o, cap_flag_o, buf_valid_o, err_flag_o, irq_o,
                   e.data, e.cf, e.bv, e.err, e.irq);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    push_exp("R1 reset state");
    @(negedge clk);
    rst = 1'b0;
    cap_ie_i = 1'b1; err_ie_i = 1'b1;

    step(0, 16'h0000, 1, 0, 0, "R11 read on empty channel");
    step(1, 16'h1111, 0, 0, 0, "R2 capture into empty");
    step(1, 16'h2222, 0, 0, 0, "R3 capture into buffer");
    step(1, 16'h3333, 0, 0, 0, "R4 overflow rejected");
    step(0, 16'h0000, 0, 0, 0, "R8 error flag holds");
    step(0, 16'h0000, 1, 0, 0, "R5 read moves buffer forward");
    step(1, 16'h4444, 0, 0, 0, "R3 refill buffer");
    step(1, 16'h5555, 1, 0, 0, "R7 read then capture when full");
    step(0, 16'h0000, 1, 0, 0, "R5 pop second entry");
    step(0, 16'h0000, 1, 0, 0, "R6 last read clears flag");
    step(0, 16'h0000, 0, 0, 1, "R8 error cleared");
    step(1, 16'h6666, 0, 0, 0, "R2 capture after drain");
    step(1, 16'h7777, 0, 0, 0, "R3 second capture");
    step(1, 16'h8888, 0, 0, 1, "R8 overflow beats error clear");
    step(0, 16'h0000, 0, 0, 1, "R8 clear error");
    cap_ie_i = 1'b0;
    step(0, 16'h0000, 0, 0, 0, "R10 capture irq masked");
    cap_ie_i = 1'b1;
    step(1, 16'h9999, 0, 1, 0, "R9 clear then capture into register");
    step(0, 16'h0000, 0, 1, 0, "R9 clear flags");
    step(0, 16'h0000, 1, 0, 0, "R11 empty read after clear");
    step(0, 16'h0000, 0, 0, 0, "R12 channel stays empty");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule